// File: doc/BRIEF.md
# Bang-Bang Digital Clock Recovery Loop

This block recovers a bit-cell clock from an oversampled serial stream whose transitions have already been detected, such as the read channel of a floppy drive. It runs on a single system clock that is many times faster than the bit rate. One input strobe arrives for each flux transition. A numerically controlled oscillator with a fixed-point phase accumulator produces one tick per unit interval. Because the period carries fraction bits, the spacing between ticks can move between two whole cycle counts so that its average matches the true cell length.

Tracking is only one stage. Before it starts, the loop measures the gaps between the first few transitions and takes the shortest one as its starting period. Media of different densities therefore need no setup. Once tracking, each transition is compared against the nearest tick, and only the sign of that comparison is used. A fixed-size correction then moves both the phase and the period. The downstream line decoder receives a tick strobe, a data bit with each tick, the period estimate, and a lock flag built from the pattern of error signs.

Top module: `cdr_bangbang`

## Requirements
- R1: While reset is held and right after it, `tick_o`, `bit_o` and `lock_o` are 0 and `period_o` equals PER_MAX whole cycles. `period_o` is unsigned fixed point with FRAC_W fraction bits.
- R2: After the first transition, the loop measures SEED_N gaps between transitions, each counted in system-clock cycles. On the cycle after the last of those transitions, `period_o` holds the smallest gap as a whole number, clamped to [PER_MIN, PER_MAX].
- R3: The oscillator phase is set to zero at the transition that completes seeding. With no further transitions, the first tick appears exactly one seeded period after it.
- R4: A transition in the first half of the current cell (elapsed phase below half the period) counts as late. The period grows by PER_STEP, and that cycle's phase increment shrinks by PH_STEP, so the next tick is delayed.
- R5: A transition in the second half counts as early. The period shrinks by PER_STEP, and that cycle's phase increment grows by PH_STEP, so the next tick is advanced.
- R6: `period_o` never leaves [PER_MIN, PER_MAX] in whole cycles, and two ticks are never on consecutive cycles.
- R7: When the period has a fractional part, tick spacing takes only the two whole-cycle values that bracket it. Over many cells the average spacing equals the period.
- R8: `bit_o` is only ever high together with `tick_o`. Each tick reports the cell of the tick before it. That bit is 1 when a transition fell within half a period on either side of that earlier tick, including the phase-zero seeding transition.
- R9: `lock_o` rises once LOCK_CNT sign alternations of the phase error have been seen without an intervening run of UNLOCK_RUN equal signs. Lock is only possible while tracking.
- R10: A run of UNLOCK_RUN consecutive phase errors of the same sign clears `lock_o` and restarts the alternation count.
- R11: No tick is produced before seeding completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| edge_i | input | 1 | One-cycle strobe per detected transition |
| tick_o | output | 1 | One-cycle strobe per recovered bit cell |
| bit_o | output | 1 | Data bit for the cell reported with this tick |
| period_o | output | INT_W+FRAC_W (16) | Current period estimate in cycles, FRAC_W fraction bits |
| lock_o | output | 1 | Loop considered locked |

## Verification
The bench builds the block with 8 fraction bits, a period range of 8 to 64 cycles, a period step of 8/256 cycle, a phase step of one whole cycle, four seeding gaps, a lock threshold of 12 alternations and an unlock run of 6. A 20-cycle cell with a phase step of one cycle gives tick positions that can be predicted exactly to the cycle for single late and early transitions. The 1/32-cycle fraction left after one late correction shows the short/long tick pattern within 64 cells. Seeding gaps of 5 and above 100 cycles reach both clamps. A cell of 20.25 cycles with occasional one-cycle jitter exercises frequency pull-in, and transitions on every cycle force a same-sign run that drops lock.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  // Acquisition phases of the loop
  typedef enum logic [1:0] {
    ACQ_IDLE  = 2'd0,
    ACQ_MEAS  = 2'd1,
    ACQ_TRACK = 2'd2
  } acq_state_e;

  // Sign of one phase-detector decision
  typedef struct packed {
    logic early;
    logic late;
  } pd_event_t;
endpackage

// File: rtl/cdr_seed.sv
// Seeding: measures SEED_N gaps after the first transition, keeps the
// smallest, then hands over to tracking with a one-cycle load strobe.
module cdr_seed
  import cdr_pkg::*;
#(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned INT_W   = 8,
  parameter int unsigned SEED_N  = 4,
  parameter int unsigned PER_MIN = 8,
  parameter int unsigned PER_MAX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic             load_o,
  output logic             track_o,
  output logic [INT_W-1:0] seed_o
);
  localparam int unsigned NW = $clog2(SEED_N + 1);

  acq_state_e       st_q, st_d;
  logic [CNT_W-1:0] gap_q, gap_d, min_q, min_d, cand;
  logic [NW-1:0]    n_q, n_d;
  logic             gap_en, meas_en;

  always_comb begin
    gap_en  = (st_q != ACQ_TRACK);
    meas_en = edge_i && (st_q != ACQ_TRACK);
    gap_d   = edge_i ? CNT_W'(1) : ((&gap_q) ? gap_q : gap_q + CNT_W'(1));
    cand    = (gap_q < min_q) ? gap_q : min_q;
    st_d    = st_q;
    min_d   = min_q;
    n_d     = n_q;
    load_o  = 1'b0;
    case (st_q)
      ACQ_IDLE: begin
        st_d  = ACQ_MEAS;
        min_d = '1;
        n_d   = '0;
      end
      ACQ_MEAS: begin
        min_d = cand;
        n_d   = n_q + NW'(1);
        if (n_d == NW'(SEED_N)) begin
          st_d   = ACQ_TRACK;
          load_o = edge_i;
        end
      end
      default: st_d = st_q;
    endcase
    if (cand < CNT_W'(PER_MIN))      seed_o = INT_W'(PER_MIN);
    else if (cand > CNT_W'(PER_MAX)) seed_o = INT_W'(PER_MAX);
    else                             seed_o = INT_W'(cand);
    track_o = (st_q == ACQ_TRACK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (gap_en) begin
      gap_q <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ACQ_IDLE;
      min_q <= '1;
      n_q   <= '0;
    end else if (meas_en) begin
      st_q  <= st_d;
      min_q <= min_d;
      n_q   <= n_d;
    end
  end
endmodule

// File: rtl/cdr_nco.sv
// Fractional phase accumulator and period register with fixed-step
// corrections and range clamp.
module cdr_nco #(
  parameter int unsigned INT_W    = 8,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned PER_MIN  = 8,
  parameter int unsigned PER_MAX  = 64,
  parameter int unsigned PER_STEP = 8,
  parameter int unsigned PH_STEP  = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [INT_W-1:0]        seed_i,
  input  logic                    track_i,
  input  logic                    early_i,
  input  logic                    late_i,
  output logic [INT_W+FRAC_W-1:0] ph_o,
  output logic [INT_W+FRAC_W-1:0] per_o,
  output logic                    wrap_o
);
  localparam int unsigned PW    = INT_W + FRAC_W;
  localparam logic [PW:0] ONE_X = (PW+1)'(1) << FRAC_W;
  localparam logic [PW:0] PHS_X = (PW+1)'(PH_STEP);
  localparam logic [PW-1:0] MINF = PW'(PER_MIN) << FRAC_W;
  localparam logic [PW-1:0] MAXF = PW'(PER_MAX) << FRAC_W;
  localparam logic [PW-1:0] STEP = PW'(PER_STEP);

  logic [PW-1:0] ph_q, ph_d, per_q, per_d;
  logic [PW:0]   inc, nxt;
  logic          ph_en, per_en;

  always_comb begin
    inc = ONE_X;
    if (early_i) inc = inc + PHS_X;
    if (late_i)  inc = inc - PHS_X;
    nxt    = {1'b0, ph_q} + inc;
    wrap_o = track_i && (nxt >= {1'b0, per_q});
    if (load_i)      ph_d = ONE_X[PW-1:0];
    else if (wrap_o) ph_d = PW'(nxt - {1'b0, per_q});
    else             ph_d = nxt[PW-1:0];
    ph_en = load_i || track_i;

    per_d = per_q;
    if (load_i) begin
      per_d = PW'(seed_i) << FRAC_W;
    end else if (early_i) begin
      per_d = (per_q < MINF + STEP) ? MINF : per_q - STEP;
    end else if (late_i) begin
      per_d = (per_q > MAXF - STEP) ? MAXF : per_q + STEP;
    end
    per_en = load_i || (track_i && (early_i || late_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= MAXF;
    end else if (per_en) begin
      per_q <= per_d;
    end
  end

  assign ph_o  = ph_q;
  assign per_o = per_q;
endmodule

// File: rtl/cdr_pd.sv
// Binary phase detector and per-cell edge flags.
module cdr_pd
  import cdr_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  input  logic          track_i,
  input  logic          load_i,
  input  logic [PW-1:0] ph_i,
  input  logic [PW-1:0] per_i,
  input  logic          wrap_i,
  output pd_event_t     ev_o,
  output logic          tick_o,
  output logic          bit_o
);
  logic first_half;
  logic prev_q, prev_d, nxt_q, nxt_d, tick_d, bit_d, tick_q, bit_q;
  logic flag_en;

  always_comb begin
    first_half = (ph_i < (per_i >> 1));
    ev_o.late  = track_i && edge_i && first_half;
    ev_o.early = track_i && edge_i && !first_half;
    prev_d  = prev_q;
    nxt_d   = nxt_q;
    tick_d  = 1'b0;
    bit_d   = 1'b0;
    flag_en = load_i || track_i;
    if (load_i) begin
      prev_d = 1'b1;
      nxt_d  = 1'b0;
    end else if (wrap_i) begin
      tick_d = 1'b1;
      bit_d  = prev_q || ev_o.late;
      prev_d = nxt_q || ev_o.early;
      nxt_d  = 1'b0;
    end else begin
      if (ev_o.late)  prev_d = 1'b1;
      if (ev_o.early) nxt_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      nxt_q  <= 1'b0;
    end else if (flag_en) begin
      prev_q <= prev_d;
      nxt_q  <= nxt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      bit_q  <= bit_d;
    end
  end

  assign tick_o = tick_q;
  assign bit_o  = bit_q;
endmodule

// File: rtl/cdr_lock.sv
// Lock detector driven by the sequence of phase-error signs.
module cdr_lock
  import cdr_pkg::*;
#(
  parameter int unsigned LOCK_CNT   = 12,
  parameter int unsigned UNLOCK_RUN = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pd_event_t ev_i,
  output logic      lock_o
);
  localparam int unsigned AW = $clog2(LOCK_CNT + 1);
  localparam int unsigned RW = $clog2(UNLOCK_RUN + 1);

  logic          ev, last_q, have_q, lock_q, lock_d;
  logic [AW-1:0] alt_q, alt_d;
  logic [RW-1:0] run_q, run_d;

  always_comb begin
    ev    = ev_i.early || ev_i.late;
    alt_d = alt_q;
    run_d = RW'(1);
    if (have_q && (ev_i.early != last_q)) begin
      alt_d = (alt_q == AW'(LOCK_CNT)) ? alt_q : alt_q + AW'(1);
    end else if (have_q) begin
      run_d = (run_q == RW'(UNLOCK_RUN)) ? run_q : run_q + RW'(1);
    end
    lock_d = lock_q;
    if (run_d >= RW'(UNLOCK_RUN)) begin
      lock_d = 1'b0;
      alt_d  = '0;
    end else if (alt_d >= AW'(LOCK_CNT)) begin
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      have_q <= 1'b0;
      alt_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (ev) begin
      last_q <= ev_i.early;
      have_q <= 1'b1;
      alt_q  <= alt_d;
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/cdr_bangbang.sv
module cdr_bangbang
  import cdr_pkg::*;
#(
  parameter int unsigned FRAC_W     = 8,
  parameter int unsigned PER_MIN    = 8,
  parameter int unsigned PER_MAX    = 64,
  parameter int unsigned PER_STEP   = 8,
  parameter int unsigned PH_STEP    = 256,
  parameter int unsigned SEED_N     = 4,
  parameter int unsigned LOCK_CNT   = 12,
  parameter int unsigned UNLOCK_RUN = 6,
  localparam int unsigned INT_W     = $clog2(PER_MAX + 1) + 1,
  localparam int unsigned PW        = INT_W + FRAC_W,
  localparam int unsigned CNT_W     = INT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  output logic          tick_o,
  output logic          bit_o,
  output logic [PW-1:0] period_o,
  output logic          lock_o
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic             ld, trk, wrap;
  logic [INT_W-1:0] seed;
  logic [PW-1:0]    ph, per;
  pd_event_t        ev;

  // Reset asserts at once and leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  cdr_seed #(
    .CNT_W(CNT_W), .INT_W(INT_W), .SEED_N(SEED_N),
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
  ) u_seed (
    .clk(clk), .rst_n(rst_int_n), .edge_i(edge_i),
    .load_o(ld), .track_o(trk), .seed_o(seed)
  );

  cdr_nco #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
    .PER_STEP(PER_STEP), .PH_STEP(PH_STEP)
  ) u_nco (
    .clk(clk), .rst_n(rst_int_n), .load_i(ld), .seed_i(seed),
    .track_i(trk), .early_i(ev.early), .late_i(ev.late),
    .ph_o(ph), .per_o(per), .wrap_o(wrap)
  );

  cdr_pd #(.PW(PW)) u_pd (
    .clk(clk), .rst_n(rst_int_n), .edge_i(edge_i), .track_i(trk),
    .load_i(ld), .ph_i(ph), .per_i(per), .wrap_i(wrap),
    .ev_o(ev), .tick_o(tick_o), .bit_o(bit_o)
  );

  cdr_lock #(.LOCK_CNT(LOCK_CNT), .UNLOCK_RUN(UNLOCK_RUN)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .ev_i(ev), .lock_o(lock_o)
  );

  assign period_o = per;
endmodule

// File: rtl/cdr_bb_chk.sv
module cdr_bb_chk #(
  parameter int unsigned PW       = 16,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned PER_MIN  = 8,
  parameter int unsigned PER_MAX  = 64,
  parameter int unsigned PER_STEP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bitv,
  input logic [PW-1:0] per,
  input logic          lock,
  input logic          trk,
  input logic          load,
  input logic          early,
  input logic          late
);
  localparam int MINF = int'(PER_MIN) << FRAC_W;
  localparam int MAXF = int'(PER_MAX) << FRAC_W;

  assert_bit_with_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bitv |-> tick);

  assert_period_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(per) >= MINF) && (int'(per) <= MAXF));

  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> ((int'(per) <= int'($past(per)) + int'(PER_STEP)) &&
                      (int'(per) + int'(PER_STEP) >= int'($past(per)))));

  assert_no_early_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trk |-> !tick);

  assert_lock_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(early || late));

  assert_lock_tracking_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> trk);
endmodule

bind cdr_bangbang cdr_bb_chk #(
  .PW(PW), .FRAC_W(FRAC_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
  .PER_STEP(PER_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_o), .bitv(bit_o), .per(period_o),
  .lock(lock_o), .trk(trk), .load(ld), .early(ev.early), .late(ev.late)
);

// File: tb/sim_cdr_bangbang.sv
`timescale 1ns/1ps
module sim_cdr_bangbang;
  localparam int FRAC_W = 8, PER_MIN = 8, PER_MAX = 64, PER_STEP = 8;
  localparam int PH_STEP = 256, SEED_N = 4, LOCK_CNT = 12, UNLOCK_RUN = 6;
  localparam int PW = $clog2(PER_MAX + 1) + 1 + FRAC_W;

  logic clk = 1'b0, rst_n = 1'b0, edge_i = 1'b0;
  logic tick, bitv, lock;
  logic [PW-1:0] per;

  always #2.5 clk = ~clk;

  cdr_bangbang #(
    .FRAC_W(FRAC_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .PER_STEP(PER_STEP),
    .PH_STEP(PH_STEP), .SEED_N(SEED_N), .LOCK_CNT(LOCK_CNT), .UNLOCK_RUN(UNLOCK_RUN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_i), .tick_o(tick), .bit_o(bitv),
    .period_o(per), .lock_o(lock)
  );

  int n_run = 0, n_fail = 0;
  bit win = 1'b0;
  int win_ticks = 0, win_ones = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit e);
    edge_i = e;
    @(negedge clk);
    edge_i = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    edge_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int exp_seed(int a, int b, int c, int d);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    if (d < m) m = d;
    if (m < PER_MIN) m = PER_MIN;
    if (m > PER_MAX) m = PER_MAX;
    return m << FRAC_W;
  endfunction

  task automatic seed4(input int a, input int b, input int c, input int d);
    int g[4];
    g[0] = a; g[1] = b; g[2] = c; g[3] = d;
    step(1'b1);
    foreach (g[i]) begin
      repeat (g[i] - 1) step(1'b0);
      step(1'b1);
    end
  endtask

  always @(negedge clk) begin
    if (win) begin
      if (tick) win_ticks++;
      if (tick && bitv) win_ones++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit bad;
    int k, last, sum, nt, g0, g1, g2, g3;
    int bits[3];
    void'($urandom(32'd4242));

    // R1: reset values
    do_reset();
    chk(!tick && !bitv && !lock, "R1 outputs idle", {tick, bitv, lock}, 0);
    chk(int'(per) == (PER_MAX << FRAC_W), "R1 period reset", per, PER_MAX << FRAC_W);

    // R11: no tick without seeding, even after a few transitions
    bad = 0;
    repeat (3) begin
      repeat (30) begin
        if (tick) bad = 1;
        step(1'b0);
      end
      step(1'b1);
    end
    repeat (60) begin
      if (tick) bad = 1;
      step(1'b0);
    end
    chk(!bad, "R11 no tick before seed", bad, 0);

    // R2: seed from the shortest gap, directed and clamped
    do_reset();
    seed4(30, 22, 25, 40);
    chk(int'(per) == exp_seed(30, 22, 25, 40), "R2 seed minimum", per, exp_seed(30, 22, 25, 40));
    do_reset();
    seed4(5, 6, 5, 7);
    chk(int'(per) == exp_seed(5, 6, 5, 7), "R2/R6 seed low clamp", per, exp_seed(5, 6, 5, 7));
    do_reset();
    seed4(100, 90, 120, 110);
    chk(int'(per) == exp_seed(100, 90, 120, 110), "R2/R6 seed high clamp", per, exp_seed(100, 90, 120, 110));
    repeat (4) begin
      g0 = 4 + int'($urandom % 80); g1 = 4 + int'($urandom % 80);
      g2 = 4 + int'($urandom % 80); g3 = 4 + int'($urandom % 80);
      do_reset();
      seed4(g0, g1, g2, g3);
      chk(int'(per) == exp_seed(g0, g1, g2, g3), "R2 random seed", per, exp_seed(g0, g1, g2, g3));
    end

    // R3/R4: first tick one period after seed, then a late transition
    do_reset();
    seed4(20, 20, 20, 20);
    bad = 0;
    for (int i = 1; i < 20; i++) begin
      if (tick) bad = 1;
      step(1'b0);
    end
    chk(tick && !bad, "R3 first tick at one period", tick, 1);
    step(1'b1);
    chk(int'(per) == (20 << FRAC_W) + PER_STEP, "R4 late lengthens period", per, (20 << FRAC_W) + PER_STEP);
    bad = 0;
    for (int i = 21; i < 42; i++) begin
      if (tick) bad = 1;
      step(1'b0);
    end
    chk(tick && !bad, "R4 late delays tick to 42", tick, 1);

    // R7: fractional period gives 20/21 spacing averaging 20.03125
    k = 0; last = 0; nt = 0; bad = 0;
    while (nt < 64) begin
      step(1'b0);
      k++;
      if (tick) begin
        if ((k - last) != 20 && (k - last) != 21) bad = 1;
        last = k;
        nt++;
      end
    end
    sum = last;
    chk(sum >= 1281 && sum <= 1283, "R7 average spacing", sum, 1282);
    chk(!bad, "R7 spacing brackets period", bad, 0);

    // R5/R8: early transition advances tick, bits follow edges
    do_reset();
    seed4(20, 20, 20, 20);
    repeat (14) step(1'b0);
    step(1'b1);
    chk(int'(per) == (20 << FRAC_W) - PER_STEP, "R5 early shortens period", per, (20 << FRAC_W) - PER_STEP);
    k = 16; nt = 0; last = 0;
    while (nt < 3) begin
      if (tick) begin
        if (nt == 0) last = k;
        bits[nt] = int'(bitv);
        nt++;
      end
      step(1'b0);
      k++;
    end
    chk(last == 19, "R5 early advances tick to 19", last, 19);
    chk(bits[0] == 1, "R8 seed cell bit", bits[0], 1);
    chk(bits[1] == 1, "R8 early edge cell bit", bits[1], 1);
    chk(bits[2] == 0, "R8 empty cell bit", bits[2], 0);

    // R9/R10: periodic data locks, transitions every cycle unlock
    do_reset();
    seed4(20, 20, 20, 20);
    chk(!lock, "R9 not locked at seed", lock, 0);
    repeat (60) begin
      repeat (19) step(1'b0);
      step(1'b1);
    end
    chk(lock, "R9 lock on periodic data", lock, 1);
    repeat (30) step(1'b1);
    chk(!lock, "R10 same-sign run unlocks", lock, 0);

    // R8/R9: jittered run-length data with a 20.25-cycle cell
    do_reset();
    begin
      int c = 0, cur = 0, t = 0, j = 0, c_start = 0, c_end = 0;
      for (int e = 0; e < 520; e++) begin
        if (e == 200) begin
          win = 1'b1;
          c_start = cur;
        end
        if (e == 500) begin
          win = 1'b0;
          c_end = cur;
          chk(lock, "R9 lock on jittered data", lock, 1);
        end
        if (e < 10) begin
          c = e; j = 0;
        end else begin
          c = c + 1 + int'($urandom % 3);
          j = 0;
          if (($urandom % 8) == 0) j = (($urandom % 2) == 0) ? 1 : -1;
        end
        t = (c * 2025 + 50) / 100 + j;
        while (cur < t) begin
          step(1'b0);
          cur++;
        end
        step(1'b1);
        cur++;
      end
      nt = (c_end - c_start) * 100 / 2025;
      chk(win_ticks >= nt - 3 && win_ticks <= nt + 3, "R7 tick count tracks cell rate", win_ticks, nt);
      chk(win_ones >= 297 && win_ones <= 303, "R8 one bit per transition", win_ones, 300);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule